// File: doc/BRIEF.md
# Rectifier Bus Start-Up Sequencer

This block steps a three-phase boost rectifier from power-on to closed-loop bus regulation. From idle it waits for the ADC offset check, then for grid detection. It then lets the bus charge through the inrush resistors with every switch off. When the bus voltage has stopped rising, it closes the bypass relay. After a second wait for the bus to settle, it hands over to the voltage-control state. In that state the regulator is enabled and follows a bus reference that climbs from the present bus sample to the final target.

Two fault sources force the PWM stage off at once: a gate-driver desaturation flag and a software protection request. The block also enters its fault state on a failed offset check, a grid-detection error, or a wait state that runs too long. It stays in the fault state until an explicit clear command arrives with no trip active, or until reset.

Top module: `bus_startup_seq`

## Requirements
- R1: While reset is asserted and after its release, the block shows state code 0 (idle), relay open, regulator disabled, bus reference 0 and fault 0. With no trip input, the PWM stop is 0.
- R2: State codes are idle=0, offset check=1, grid detect=2, precharge=3, relay settle=4, voltage control=5, fault=6. Idle moves to offset check on the next clock. Offset check moves to grid detect on offset-done with offset-ok. Grid detect moves to precharge on grid-lock.
- R3: Offset-done with offset-ok low, or a grid error during grid detect, moves the block to fault on the next clock.
- R4: In precharge, a bus sample is taken on each cycle with sample-valid high. The first sample in the state only sets the comparison point. After SETTLE_N consecutive samples, each differing from the previous one by strictly less than DELTA, the relay closes and the state becomes 4 one clock later. A larger difference restarts the count.
- R5: In state 4 the relay stays closed while a fresh settle count, following the same rule as R4, is run. It starts anew on entry, and when it completes the block moves to voltage control with the relay still closed.
- R6: The regulator enable is high only in voltage control.
- R7: On entry to voltage control, the bus reference equals the present bus sample, limited to BUS_TARGET. It then rises by RAMP_STEP every RAMP_DIV clocks, lands exactly on BUS_TARGET and never exceeds it.
- R8: PWM stop rises in the same cycle as the desaturation or software trip input. On the next clock the block is in fault, with the relay open, the regulator off and the reference 0.
- R9: Fault and PWM stop stay set after the trip is removed. A clear command is ignored while a trip is active. A clear command with no trip active returns the block to idle on the next clock.
- R10: A wait state (codes 1 to 4) that lasts TMO clocks moves the block to fault on that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_v | input | VW | Digitized DC bus voltage |
| smp_vld | input | 1 | bus_v holds a new sample this cycle |
| offs_done | input | 1 | Offset check finished |
| offs_ok | input | 1 | Offset check result good |
| grid_lock | input | 1 | Grid frequency and phase acquired |
| grid_err | input | 1 | Grid detection failed |
| desat | input | 1 | Gate-driver desaturation flag |
| sw_trip | input | 1 | Software protection request |
| clr_cmd | input | 1 | Fault clear command |
| relay_on | output | 1 | Inrush bypass relay drive |
| bus_ref | output | VW | Bus voltage reference for the regulator |
| reg_en | output | 1 | Closed-loop regulator enable |
| pwm_stop | output | 1 | Global PWM stop |
| fault | output | 1 | Latched fault |
| seq_state | output | 3 | Sequencer state code |

## Verification
A table of bus sample values drives the settle detector through both waiting phases. In the table, a large jump restarts the count, and a jump exactly equal to DELTA restarts it too. That second case separates a strict comparison from an inclusive one. Runs of small changes must complete at exactly the sample that finishes the count. A flat 700 run then exercises the ramp, whose values before the end and at the clamp step show the slope, the period and the exact landing on the target. Directed runs cover each fault cause, the timeout boundary one clock either side, and a clear command blocked by an active trip.

// File: rtl/bss_pkg.sv
package bss_pkg;
  localparam int VW = 12;
  typedef logic [VW-1:0] volt_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_OFFS   = 3'd1,
    ST_GRID   = 3'd2,
    ST_PRECHG = 3'd3,
    ST_BYPASS = 3'd4,
    ST_VCTRL  = 3'd5,
    ST_FAULT  = 3'd6
  } seq_st_t;

  // true when two samples differ by strictly less than d
  function automatic logic step_small(volt_t a, volt_t b, volt_t d);
    volt_t diff;
    diff = (a >= b) ? (a - b) : (b - a);
    return diff < d;
  endfunction

  function automatic volt_t vmin(volt_t a, volt_t b);
    return (a < b) ? a : b;
  endfunction

  // one ramp increment, landing exactly on tgt
  function automatic volt_t ramp_next(volt_t r, volt_t step, volt_t tgt);
    if (r >= tgt) return tgt;
    if ((tgt - r) <= step) return tgt;
    return r + step;
  endfunction
endpackage

// File: rtl/bss_settle.sv
module bss_settle
  import bss_pkg::*;
#(
  parameter int    SETTLE_N = 4,
  parameter volt_t DELTA    = volt_t'(3)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  smp_vld,
  input  volt_t smp,
  output logic  settled
);
  localparam int CW = $clog2(SETTLE_N + 1);

  volt_t         prev_q;
  logic          have_q;
  logic [CW-1:0] cnt_q;
  logic          step_ok;

  assign step_ok = have_q && step_small(smp, prev_q, DELTA);
  assign settled = (cnt_q == CW'(SETTLE_N));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      prev_q <= '0;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (smp_vld) begin
      prev_q <= smp;
      have_q <= 1'b1;
      if (!step_ok)      cnt_q <= '0;
      else if (!settled) cnt_q <= cnt_q + CW'(1);
    end
  end

  // R4
  settle_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $past(smp_vld));

  // R5
  settle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !settled);
endmodule

// File: rtl/bss_ramp.sv
module bss_ramp
  import bss_pkg::*;
#(
  parameter volt_t STEP   = volt_t'(16),
  parameter int    DIV    = 8,
  parameter volt_t TARGET = volt_t'(800)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  run,
  input  volt_t start_v,
  output volt_t ref_v
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  volt_t         ref_q;
  logic [DW-1:0] div_q;
  logic          tick;

  assign tick  = (div_q == DW'(DIV - 1));
  assign ref_v = ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q <= '0;
      div_q <= '0;
    end else if (load) begin
      ref_q <= vmin(start_v, TARGET);
      div_q <= '0;
    end else if (run) begin
      if (tick) begin
        div_q <= '0;
        ref_q <= ramp_next(ref_q, STEP, TARGET);
      end else begin
        div_q <= div_q + DW'(1);
      end
    end else begin
      ref_q <= '0;
      div_q <= '0;
    end
  end

  // R7
  ramp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_q <= TARGET);

  // R7
  ramp_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> (ref_q >= $past(ref_q)) && ((ref_q - $past(ref_q)) <= STEP));
endmodule

// File: rtl/bss_fault.sv
module bss_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic fault_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   fault_q <= 1'b0;
    else if (set) fault_q <= 1'b1;
    else if (clr) fault_q <= 1'b0;
  end

  // R9
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_q && !clr) |=> fault_q);

  // R9
  fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> fault_q);
endmodule

// File: rtl/bus_startup_seq.sv
module bus_startup_seq
  import bss_pkg::*;
#(
  parameter int    SETTLE_N   = 4,
  parameter volt_t DELTA      = volt_t'(3),
  parameter volt_t RAMP_STEP  = volt_t'(16),
  parameter int    RAMP_DIV   = 8,
  parameter volt_t BUS_TARGET = volt_t'(800),
  parameter int    TMO        = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] bus_v,
  input  logic          smp_vld,
  input  logic          offs_done,
  input  logic          offs_ok,
  input  logic          grid_lock,
  input  logic          grid_err,
  input  logic          desat,
  input  logic          sw_trip,
  input  logic          clr_cmd,
  output logic          relay_on,
  output logic [VW-1:0] bus_ref,
  output logic          reg_en,
  output logic          pwm_stop,
  output logic          fault,
  output logic [2:0]    seq_state
);
  localparam int TW = $clog2(TMO + 1);

  seq_st_t       st_q, st_d;
  logic [TW-1:0] tmr_q;
  logic          trip, in_wait, timed_out, seq_err, fault_set;
  logic          settled, settle_clr, ramp_load, ramp_run, fault_q;
  volt_t         ramp_ref;

  // named internal events
  assign trip       = desat | sw_trip;
  assign in_wait    = (st_q == ST_OFFS) || (st_q == ST_GRID) ||
                      (st_q == ST_PRECHG) || (st_q == ST_BYPASS);
  assign timed_out  = in_wait && (tmr_q == TW'(TMO - 1));

  always_comb begin
    seq_err = timed_out;
    case (st_q)
      ST_OFFS: if (offs_done && !offs_ok) seq_err = 1'b1;
      ST_GRID: if (grid_err)              seq_err = 1'b1;
      default: ;
    endcase
  end

  assign fault_set = trip | seq_err;

  always_comb begin
    st_d = st_q;
    if (fault_set) begin
      st_d = ST_FAULT;
    end else begin
      case (st_q)
        ST_IDLE:   st_d = ST_OFFS;
        ST_OFFS:   if (offs_done && offs_ok) st_d = ST_GRID;
        ST_GRID:   if (grid_lock) st_d = ST_PRECHG;
        ST_PRECHG: if (settled) st_d = ST_BYPASS;
        ST_BYPASS: if (settled) st_d = ST_VCTRL;
        ST_VCTRL:  st_d = ST_VCTRL;
        ST_FAULT:  if (clr_cmd) st_d = ST_IDLE;
        default:   st_d = ST_FAULT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tmr_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= (st_d != st_q || !in_wait) ? '0 : tmr_q + TW'(1);
    end
  end

  assign settle_clr = (st_d != st_q) || !((st_q == ST_PRECHG) || (st_q == ST_BYPASS));
  assign ramp_load  = (st_d == ST_VCTRL) && (st_q != ST_VCTRL);
  assign ramp_run   = (st_q == ST_VCTRL);

  bss_settle #(.SETTLE_N(SETTLE_N), .DELTA(DELTA)) u_settle (
    .clk(clk), .rst_n(rst_n), .clr(settle_clr),
    .smp_vld(smp_vld), .smp(bus_v), .settled(settled)
  );

  bss_ramp #(.STEP(RAMP_STEP), .DIV(RAMP_DIV), .TARGET(BUS_TARGET)) u_ramp (
    .clk(clk), .rst_n(rst_n), .load(ramp_load), .run(ramp_run),
    .start_v(bus_v), .ref_v(ramp_ref)
  );

  bss_fault u_fault (
    .clk(clk), .rst_n(rst_n), .set(fault_set), .clr(clr_cmd), .fault_q(fault_q)
  );

  assign relay_on  = (st_q == ST_BYPASS) || (st_q == ST_VCTRL);
  assign reg_en    = (st_q == ST_VCTRL);
  assign bus_ref   = reg_en ? ramp_ref : '0;
  assign pwm_stop  = trip | fault_q;
  assign fault     = fault_q;
  assign seq_state = st_q;

  // R2
  prechg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PRECHG && $past(st_q) != ST_PRECHG) |-> $past(st_q) == ST_GRID);

  // R5
  relay_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(relay_on) |-> $past(st_q) == ST_PRECHG);

  // R6
  reg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_en) |-> $past(st_q) == ST_BYPASS);

  // R8
  trip_to_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> (st_q == ST_FAULT) && !relay_on && !reg_en);

  // R9
  latch_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q == (st_q == ST_FAULT));

  // R10
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_q < TW'(TMO));
endmodule

// File: tb/bus_startup_seq_test.sv
`timescale 1ns/1ps
module bus_startup_seq_test;
  localparam int TMO_T = 200;
  localparam int DIV_T = 8;
  localparam int NV    = 15;
  // bus samples fed in precharge and relay-settle, with expected state after each
  localparam int TV_BUS [0:NV-1] = '{100, 150, 152, 154, 157, 158, 160, 161, 162,
                                     162, 170, 171, 172, 173, 174};
  localparam int TV_ST  [0:NV-1] = '{3, 3, 3, 3, 3, 3, 3, 3, 4,
                                     4, 4, 4, 4, 4, 5};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_v = '0;
  logic        smp_vld = 1'b0, offs_done = 1'b0, offs_ok = 1'b0;
  logic        grid_lock = 1'b0, grid_err = 1'b0, desat = 1'b0, sw_trip = 1'b0, clr_cmd = 1'b0;
  logic        relay_on, reg_en, pwm_stop, fault;
  logic [11:0] bus_ref;
  logic [2:0]  seq_state;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  bus_startup_seq #(.SETTLE_N(4), .DELTA(12'd3), .RAMP_STEP(12'd16), .RAMP_DIV(DIV_T),
                    .BUS_TARGET(12'd800), .TMO(TMO_T)) uut (
    .clk(clk), .rst_n(rst_n), .bus_v(bus_v), .smp_vld(smp_vld),
    .offs_done(offs_done), .offs_ok(offs_ok), .grid_lock(grid_lock), .grid_err(grid_err),
    .desat(desat), .sw_trip(sw_trip), .clr_cmd(clr_cmd),
    .relay_on(relay_on), .bus_ref(bus_ref), .reg_en(reg_en), .pwm_stop(pwm_stop),
    .fault(fault), .seq_state(seq_state)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sample(input int v);
    bus_v = 12'(v); smp_vld = 1'b1;
    tick(1);
    smp_vld = 1'b0;
    tick(1);
  endtask

  // from fault: clear, expect idle then offset check
  task automatic restart();
    clr_cmd = 1'b1; tick(1); clr_cmd = 1'b0;
    chk("R9", int'(seq_state), 0);
    chk("R9", int'(pwm_stop), 0);
    tick(1);
    chk("R2", int'(seq_state), 1);
  endtask

  task automatic go_prechg();
    offs_done = 1'b1; offs_ok = 1'b1; tick(1);
    offs_done = 1'b0; offs_ok = 1'b0;
    chk("R2", int'(seq_state), 2);
    grid_lock = 1'b1; tick(1); grid_lock = 1'b0;
    chk("R2", int'(seq_state), 3);
    chk("R2", int'(relay_on), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    chk("R1", int'(seq_state), 0);
    chk("R1", int'(relay_on), 0);
    chk("R1", int'(reg_en), 0);
    chk("R1", int'(bus_ref), 0);
    chk("R1", int'(pwm_stop), 0);
    chk("R1", int'(fault), 0);
    rst_n = 1'b1;
    tick(1);
    chk("R2", int'(seq_state), 1);
    go_prechg();

    // table walk: R4 in precharge, R5 in relay settle, R6 enable
    for (int i = 0; i < NV; i++) begin
      sample(TV_BUS[i]);
      chk((i < 9) ? "R4" : "R5", int'(seq_state), TV_ST[i]);
      chk((i < 9) ? "R4" : "R5", int'(relay_on), (TV_ST[i] >= 4) ? 1 : 0);
      chk("R6", int'(reg_en), (TV_ST[i] == 5) ? 1 : 0);
    end
    chk("R7", int'(bus_ref), 174);

    // R8 desaturation trip
    desat = 1'b1; #1;
    chk("R8", int'(pwm_stop), 1);
    tick(1);
    chk("R8", int'(seq_state), 6);
    chk("R8", int'(relay_on), 0);
    chk("R8", int'(reg_en), 0);
    chk("R8", int'(bus_ref), 0);
    desat = 1'b0;
    tick(3);
    chk("R9", int'(seq_state), 6);
    chk("R9", int'(pwm_stop), 1);
    chk("R9", int'(fault), 1);
    sw_trip = 1'b1; clr_cmd = 1'b1; tick(1);
    sw_trip = 1'b0; clr_cmd = 1'b0;
    chk("R9", int'(seq_state), 6);
    restart();

    // R7 ramp from a flat 700 bus
    go_prechg();
    for (int i = 0; i < 10; i++) sample(700);
    chk("R7", int'(seq_state), 5);
    chk("R7", int'(bus_ref), 700);
    tick(DIV_T - 1);
    chk("R7", int'(bus_ref), 700);
    tick(1);
    chk("R7", int'(bus_ref), 716);
    tick(5 * DIV_T);
    chk("R7", int'(bus_ref), 796);
    tick(DIV_T);
    chk("R7", int'(bus_ref), 800);
    tick(2 * DIV_T);
    chk("R7", int'(bus_ref), 800);

    // R8 software trip in voltage control
    sw_trip = 1'b1; #1;
    chk("R8", int'(pwm_stop), 1);
    tick(1); sw_trip = 1'b0;
    chk("R8", int'(seq_state), 6);
    restart();

    // R3 offset failure
    offs_done = 1'b1; offs_ok = 1'b0; tick(1); offs_done = 1'b0;
    chk("R3", int'(seq_state), 6);
    restart();

    // R3 grid error
    offs_done = 1'b1; offs_ok = 1'b1; tick(1);
    offs_done = 1'b0; offs_ok = 1'b0;
    grid_err = 1'b1; tick(1); grid_err = 1'b0;
    chk("R3", int'(seq_state), 6);
    restart();

    // R10 timeout in offset check
    tick(TMO_T - 1);
    chk("R10", int'(seq_state), 1);
    tick(1);
    chk("R10", int'(seq_state), 6);
    chk("R10", int'(fault), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule